// File: doc/BRIEF.md
# Sprite Page Copy DMA

This block moves one full 256-byte page from the processor's address space into sprite attribute memory. Software starts it by writing a page number to the trigger address. The processor is halted until the copy ends. During the copy the block owns the bus.

A copy starts with one or two alignment cycles that carry no strobe. The number depends on the parity of the cycle in which the trigger write arrives. After those come 256 pairs of bus cycles. Each pair is a read from the source page followed by a write of that byte to the sprite data port. The block does not write sprite RAM directly. The halt therefore lasts 513 or 514 cycles.

A remaining-byte count is visible on a port throughout the copy. Another DMA arbiter can use it to work out how long its own stall must be. A busy flag tells the interrupt poller to freeze its sampling.

Top module: `spr_dma_top`

## Requirements
- R1: After reset, `cpu_halt`, `dma_busy`, `bus_rd` and `bus_wr` are low, and `bytes_left` is 0.
- R2: Only a write with `cpu_wr_en` high and `cpu_wr_addr` equal to 0x4014, made while the block is idle, starts a copy. Writes to any other address leave `cpu_halt` low and no strobe appears.
- R3: An internal parity bit is cleared by reset and toggles on every clock edge after reset. The first cycle after reset release is even (parity 0). A trigger sampled in an even cycle gives one alignment cycle. A trigger sampled in an odd cycle gives two. Alignment cycles assert neither strobe.
- R4: After alignment there are 256 read cycles (`bus_rd` high). Their addresses are page × 0x100 + index, with index running 0 to 255 in ascending order. The page is the low 8 bits of `cpu_wr_data` at the trigger.
- R5: Every read cycle is followed directly by a write cycle (`bus_wr` high). The write goes to address 0x2004, and `bus_wdata` equals the `bus_rdata` sampled in the read cycle just before.
- R6: `cpu_halt` and `dma_busy` rise in the cycle after the trigger edge. They stay high for exactly 513 cycles (even trigger) or 514 cycles (odd trigger). Both are low in the cycle after the last write.
- R7: `bytes_left` reads 256 from the first cycle of the copy. It drops by one after each write cycle and reads 0 when the copy has ended.
- R8: A trigger write that arrives while a copy is running is ignored. The source page and the sequence are unchanged, and no second copy follows.
- R9: `bus_rd` and `bus_wr` are never high together, and neither is high while `cpu_halt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wr_addr | input | 16 | Processor write address |
| cpu_wr_data | input | 8 | Processor write data (source page number) |
| bus_rdata | input | 8 | Read data returned for `bus_addr` |
| bus_addr | output | 16 | Bus address driven during copy |
| bus_wdata | output | 8 | Byte driven in write cycles |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| cpu_halt | output | 1 | Processor stall request |
| dma_busy | output | 1 | Copy in progress, for the interrupt poller |
| bytes_left | output | 9 | Bytes still to be written |

## Verification
The hardest case to reach is a trigger that lands on an odd cycle. It needs the bench to know the hidden parity phase. The bench keeps its own count of edges since reset release and waits for an odd or even count before it triggers. A trigger that arrives in the middle of a copy is also hard to reach. The bench injects one at a fixed point within the halt window and with a different page. It then checks that the read addresses stay on the original page and that no second halt follows.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN_X,
        ST_ALIGN,
        ST_RD,
        ST_WR
    } dma_state_e;

endpackage

// File: rtl/spr_dma_parity.sv
module spr_dma_parity (
    input  logic clk,
    input  logic rst_n,
    output logic odd
);

    typedef struct packed {
        logic par;
    } par_reg_t;

    par_reg_t par_d, par_q;

    always_comb begin
        par_d     = par_q;
        par_d.par = ~par_q.par;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign odd = par_q.par;

    AST_PAR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (odd != $past(odd))); // R3

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_hit,
    input  logic             odd,
    output logic             accept,
    output dma_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] left
);

    typedef struct packed {
        dma_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] left;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        accept = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (trig_hit) begin
                    accept     = 1'b1;
                    seq_d.st   = odd ? ST_ALIGN_X : ST_ALIGN;
                    seq_d.idx  = '0;
                    seq_d.left = CNT_W'(PAGE_BYTES);
                end
            end
            ST_ALIGN_X: seq_d.st = ST_ALIGN;
            ST_ALIGN:   seq_d.st = ST_RD;
            ST_RD:      seq_d.st = ST_WR;
            ST_WR: begin
                seq_d.left = seq_q.left - 1'b1;
                seq_d.idx  = seq_q.idx + 1'b1;
                seq_d.st   = (seq_q.left == CNT_W'(1)) ? ST_IDLE : ST_RD;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.idx  <= '0;
            seq_q.left <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;
    assign idx   = seq_q.idx;
    assign left  = seq_q.left;

    AST_IDX_TRACKS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |-> (CNT_W'(idx) + left == CNT_W'(PAGE_BYTES))); // R4

endmodule

// File: rtl/spr_dma_datapath.sv
module spr_dma_datapath
    import spr_dma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 256,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004,
    localparam int IDX_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] page_in,
    input  dma_state_e        state,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [DATA_W-1:0] data;
    } dp_reg_t;

    dp_reg_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (accept)          dp_d.page = page_in[PAGE_W-1:0];
        if (state == ST_RD)  dp_d.data = bus_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        case (state)
            ST_RD: begin
                bus_addr = {dp_q.page, idx};
                bus_rd   = 1'b1;
            end
            ST_WR: begin
                bus_addr  = PORT_ADDR;
                bus_wdata = dp_q.data;
                bus_wr    = 1'b1;
            end
            default: ;
        endcase
    end

    AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_wr && bus_wdata == $past(bus_rdata))); // R5

    AST_WR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == PORT_ADDR)); // R5

endmodule

// File: rtl/spr_dma_top.sv
module spr_dma_top
    import spr_dma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 256,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              cpu_halt,
    output logic              dma_busy,
    output logic [CNT_W-1:0]  bytes_left
);

    logic             odd;
    logic             trig_hit;
    logic             accept;
    dma_state_e       state;
    logic [IDX_W-1:0] idx;

    assign trig_hit = cpu_wr_en && (cpu_wr_addr == TRIG_ADDR);

    spr_dma_parity u_par (
        .clk   (clk),
        .rst_n (rst_n),
        .odd   (odd)
    );

    spr_dma_seq #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_hit (trig_hit),
        .odd      (odd),
        .accept   (accept),
        .state    (state),
        .idx      (idx),
        .left     (bytes_left)
    );

    spr_dma_datapath #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .PORT_ADDR  (PORT_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .page_in   (cpu_wr_data),
        .state     (state),
        .idx       (idx),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr)
    );

    assign cpu_halt = (state != ST_IDLE);
    assign dma_busy = (state != ST_IDLE);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R9

    AST_STROBE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> cpu_halt); // R9

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !dma_busy) |=> (cpu_halt && bytes_left == CNT_W'(PAGE_BYTES))); // R7

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (bytes_left == $past(bytes_left) - 1'b1)); // R7

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bytes_left == CNT_W'(1)) |=> (!cpu_halt && !dma_busy)); // R6

    AST_IGNORE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_busy && !trig_hit) |=> !cpu_halt); // R2

endmodule

// File: tb/tb_spr_dma_top.sv
module tb_spr_dma_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_wr_addr = '0;
    logic [7:0]  cpu_wr_data = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd, bus_wr, cpu_halt, dma_busy;
    logic [8:0]  bytes_left;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] ^ 8'h5A) + (a[15:8] * 8'h3B);
    endfunction

    assign bus_rdata = mem_byte(bus_addr);

    spr_dma_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_addr (cpu_wr_addr),
        .cpu_wr_data (cpu_wr_data),
        .bus_rdata   (bus_rdata),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .cpu_halt    (cpu_halt),
        .dma_busy    (dma_busy),
        .bytes_left  (bytes_left)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 halt/busy", !cpu_halt && !dma_busy, {cpu_halt, dma_busy}, 0);
        check("R1 strobes", !bus_rd && !bus_wr, {bus_rd, bus_wr}, 0);
        check("R1 bytes_left", bytes_left == 0, bytes_left, 0);
    endtask

    task automatic t_other_addr();
        int bad = 0;
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_addr = 16'h4015; cpu_wr_data = 8'h03;
        @(negedge clk);
        if (cpu_halt || bus_rd || bus_wr) bad++;
        cpu_wr_addr = 16'h0014;
        @(negedge clk);
        if (cpu_halt || bus_rd || bus_wr) bad++;
        cpu_wr_en = 1'b0; cpu_wr_addr = 16'h4014;
        @(negedge clk);
        if (cpu_halt || bus_rd || bus_wr) bad++;
        cpu_wr_addr = '0;
        check("R2 non-trigger writes ignored", bad == 0, bad, 0);
    endtask

    task automatic t_copy(input logic [7:0] page, input bit want_odd, input bit inject);
        int halt_n = 0, align_n = 0, rd_n = 0, wr_n = 0;
        int rd_err = 0, wr_err = 0, cnt_err = 0, seq_err = 0, busy_err = 0;
        int first_left = -1;
        int expect_len;
        logic [7:0] last_val = '0;
        bit prev_rd = 0;
        expect_len = want_odd ? 514 : 513;
        @(negedge clk);
        while (cyc[0] != want_odd) @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_addr = 16'h4014; cpu_wr_data = page;
        @(negedge clk);
        cpu_wr_en = 1'b0; cpu_wr_addr = '0;
        first_left = bytes_left;
        for (int k = 0; k < 600; k++) begin
            if (!cpu_halt) break;
            halt_n++;
            if (!dma_busy) busy_err++;
            if (bus_rd && bus_wr) seq_err++;
            if (bus_rd) begin
                if (prev_rd) seq_err++;
                if (bus_addr != {page, rd_n[7:0]}) rd_err++;
                last_val = mem_byte(bus_addr);
                rd_n++;
            end else if (bus_wr) begin
                if (!prev_rd) seq_err++;
                if (bus_addr != 16'h2004 || bus_wdata != last_val) wr_err++;
                if (bytes_left != 9'(256 - wr_n)) cnt_err++;
                wr_n++;
            end else begin
                if (rd_n != 0) seq_err++;
                align_n++;
            end
            prev_rd = bus_rd;
            if (inject && halt_n == 100) begin
                cpu_wr_en = 1'b1; cpu_wr_addr = 16'h4014; cpu_wr_data = page ^ 8'h01;
            end else begin
                cpu_wr_en = 1'b0; cpu_wr_addr = '0;
            end
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;
        check("R6 halt length", halt_n == expect_len, halt_n, expect_len);
        check("R6 busy with halt", busy_err == 0, busy_err, 0);
        check("R3 alignment cycles", align_n == (want_odd ? 2 : 1), align_n, want_odd ? 2 : 1);
        check("R4 read count", rd_n == 256, rd_n, 256);
        check(inject ? "R8 R4 read addresses" : "R4 read addresses", rd_err == 0, rd_err, 0);
        check("R5 writes", wr_err == 0 && wr_n == 256, wr_err, 0);
        check("R9 R5 strobe order", seq_err == 0, seq_err, 0);
        check("R7 initial count", first_left == 256, first_left, 256);
        check("R7 count per write", cnt_err == 0, cnt_err, 0);
        check("R7 R6 end state", bytes_left == 0 && !dma_busy && !cpu_halt, bytes_left, 0);
        if (inject) begin
            int late = 0;
            for (int k = 0; k < 4; k++) begin
                if (cpu_halt || bus_rd || bus_wr) late++;
                @(negedge clk);
            end
            check("R8 no second copy", late == 0, late, 0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_other_addr();
        t_copy(8'h03, 1'b0, 1'b0);
        t_copy(8'hFF, 1'b1, 1'b0);
        t_copy(8'h00, 1'b0, 1'b1);
        t_copy(8'h80, 1'b1, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule